// File: doc/BRIEF.md
# 1-Wire ROM Search Nibble Engine

This block speeds up the ROM search on a 1-Wire bus. It sits between a host write port and an external slot-timing engine. A host write with the search mode bit set hands it four direction bits, and the engine resolves four ROM-code bit positions by itself. For each position it runs two read slots (the bit, then its complement), picks the branch bit, and runs one write slot with that bit. When all four positions are done it returns one result byte: the discrepancy flags in the low nibble and the bits actually written in the high nibble. Sixteen such writes walk a full 64-bit ROM code. Keeping track of discrepancies across nibbles and checking the CRC are left to the host.

When the mode bit is clear at the start strobe, the same write is a plain byte transfer. Eight touch slots send the data byte least significant bit first, and the result byte collects the sampled bus levels.

The slot engine is reached through a level request (`slot_req`) together with the bit to drive (`slot_bit`, where a 1 also serves as a read slot). The slot engine answers with a one-cycle acknowledge (`slot_ack`) that carries the sampled level (`slot_rbit`).

The controller has five states:
- `ST_IDLE`. Goes to `ST_RD_TRUE` on a start strobe in search mode, or to `ST_BYTE_SLOT` on a start strobe in byte mode.
- `ST_RD_TRUE`. Goes to `ST_RD_COMP` on acknowledge.
- `ST_RD_COMP`. Goes to `ST_WR_BIT` on acknowledge.
- `ST_WR_BIT`. Goes to `ST_RD_TRUE` on acknowledge while positions remain, and to `ST_IDLE` on the last acknowledge.
- `ST_BYTE_SLOT`. Stays put on acknowledge while bits remain, and goes to `ST_IDLE` on the eighth acknowledge.

Top module: `osa_search_accel`

## Requirements
- R1: After reset, `slot_req`, `done`, `no_resp` and `result` are all 0.
- R2: In search mode, one start runs exactly twelve slots. They are handled as positions 0 to 3, and each position is a read slot, a read slot, then a write slot. Read slots drive `slot_bit` = 1.
- R3: When both reads of a position return 0, the write slot drives direction bit `wr_data[i]` for position i, and discrepancy flag i is set.
- R4: When the two reads of a position differ, the write slot drives the first (true) read value, and discrepancy flag i is 0.
- R5: When both reads of a position return 1, the write slot drives 1, discrepancy flag i is 0, and `no_resp` is 1 with the result. Otherwise `no_resp` is 0 with the result.
- R6: Result bit i (for i from 0 to 3) is the discrepancy flag of position i. Result bit 4+i is the bit written for position i.
- R7: `done` is a one-cycle pulse in the cycle after the last slot acknowledge. `result` and `no_resp` change in that same cycle and hold until the next `done`. `slot_req` is low in that cycle.
- R8: The mode is sampled at the start strobe. In byte mode, eight slots drive `wr_data` least significant bit first, and result bit i is the level sampled in slot i. Changing `search_en` during an operation has no effect.
- R9: A start strobe while an operation is running is ignored. It changes neither the slots nor the result.
- R10: `slot_req` stays high with a stable `slot_bit` until `slot_ack` is seen. It is high only while an operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Search mode select, sampled at start |
| start | input | 1 | Start strobe, accepted only when idle |
| wr_data | input | BYTE_BITS | Byte to send, or direction bits in the low nibble |
| slot_req | output | 1 | Slot request level to the timing engine |
| slot_bit | output | 1 | Level to drive in the requested slot (1 = read) |
| slot_ack | input | 1 | One-cycle slot completion |
| slot_rbit | input | 1 | Sampled bus level, valid with `slot_ack` |
| done | output | 1 | Operation complete pulse |
| result | output | BYTE_BITS | Packed flags and bits, or received byte |
| no_resp | output | 1 | Some position read 1 on both reads |

## Verification
The assertions assume the slot engine pulses `slot_ack` for a single cycle and only while `slot_req` is high. They also assume that an acknowledge is never held across two slots. The bench meets this by driving its slot responder on the falling edge, counting a latency of one to three cycles after it sees the request, and raising the acknowledge for exactly one cycle. The bench also drives `start` for one cycle only, and never in the same cycle as an acknowledge that it has not yet modelled.

// File: rtl/osa_pkg.sv
package osa_pkg;
    localparam int NIB_BITS     = 4;
    localparam int BYTE_BITS    = 2 * NIB_BITS;
    localparam int SEARCH_SLOTS = 3 * NIB_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TRUE,
        ST_RD_COMP,
        ST_WR_BIT,
        ST_BYTE_SLOT
    } osa_state_e;
endpackage

// File: rtl/osa_branch.sv
// Branch decision for one ROM position from its true and complement reads.
module osa_branch (
    input  logic true_bit,
    input  logic comp_bit,
    input  logic dir_bit,
    output logic wr_bit,
    output logic disc,
    output logic no_dev
);
    always_comb begin
        wr_bit = true_bit;
        disc   = 1'b0;
        no_dev = 1'b0;
        if (!true_bit && !comp_bit) begin
            wr_bit = dir_bit;
            disc   = 1'b1;
        end else if (true_bit && comp_bit) begin
            wr_bit = 1'b1;
            no_dev = 1'b1;
        end
    end
endmodule

// File: rtl/osa_pos_cnt.sv
// Position counter with a run-time limit.
module osa_pos_cnt #(
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [POS_W-1:0] limit,
    output logic [POS_W-1:0] pos,
    output logic             at_limit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pos <= '0;
        else if (clear)  pos <= '0;
        else if (step)   pos <= pos + 1'b1;
    end

    assign at_limit = (pos == limit);
endmodule

// File: rtl/osa_search_accel.sv
module osa_search_accel
    import osa_pkg::*;
#(
    parameter int NIB_W  = osa_pkg::NIB_BITS,
    parameter int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              search_en,
    input  logic              start,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              slot_req,
    output logic              slot_bit,
    input  logic              slot_ack,
    input  logic              slot_rbit,
    output logic              done,
    output logic [BYTE_W-1:0] result,
    output logic              no_resp
);
    localparam int POS_W = $clog2(BYTE_W);

    osa_state_e        state_q, state_d;
    logic [BYTE_W-1:0] data_q, acc_q, acc_d;
    logic              nores_q, nores_d;
    logic              true_q, wbit_q;
    logic              fin;
    logic              ack_ok;
    logic [POS_W-1:0]  pos, limit;
    logic              at_limit, cnt_clear, cnt_step;
    logic              br_wr, br_disc, br_nodev;

    assign ack_ok    = slot_ack && slot_req;
    assign limit     = (state_q == ST_BYTE_SLOT) ? POS_W'(BYTE_W - 1) : POS_W'(NIB_W - 1);
    assign cnt_clear = (state_q == ST_IDLE) && start;
    assign cnt_step  = ack_ok && !at_limit &&
                       ((state_q == ST_WR_BIT) || (state_q == ST_BYTE_SLOT));

    osa_pos_cnt #(.POS_W(POS_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .step     (cnt_step),
        .limit    (limit),
        .pos      (pos),
        .at_limit (at_limit)
    );

    osa_branch u_branch (
        .true_bit (true_q),
        .comp_bit (slot_rbit),
        .dir_bit  (data_q[pos]),
        .wr_bit   (br_wr),
        .disc     (br_disc),
        .no_dev   (br_nodev)
    );

    // Next-state and accumulator update
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        nores_d = nores_q;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = search_en ? ST_RD_TRUE : ST_BYTE_SLOT;
                    acc_d   = '0;
                    nores_d = 1'b0;
                end
            end
            ST_RD_TRUE: begin
                if (ack_ok) state_d = ST_RD_COMP;
            end
            ST_RD_COMP: begin
                if (ack_ok) begin
                    acc_d[pos]               = br_disc;
                    acc_d[NIB_W + int'(pos)] = br_wr;
                    nores_d                  = nores_q | br_nodev;
                    state_d                  = ST_WR_BIT;
                end
            end
            ST_WR_BIT: begin
                if (ack_ok) begin
                    if (at_limit) begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end else begin
                        state_d = ST_RD_TRUE;
                    end
                end
            end
            ST_BYTE_SLOT: begin
                if (ack_ok) begin
                    acc_d[pos] = slot_rbit;
                    if (at_limit) begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Slot request outputs
    always_comb begin
        slot_req = 1'b1;
        slot_bit = 1'b1;
        unique case (state_q)
            ST_IDLE:      slot_req = 1'b0;
            ST_RD_TRUE,
            ST_RD_COMP:   slot_bit = 1'b1;
            ST_WR_BIT:    slot_bit = wbit_q;
            ST_BYTE_SLOT: slot_bit = data_q[pos];
            default:      slot_req = 1'b0;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            acc_q   <= '0;
            nores_q <= 1'b0;
            true_q  <= 1'b0;
            wbit_q  <= 1'b0;
            result  <= '0;
            no_resp <= 1'b0;
            done    <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            nores_q <= nores_d;
            done    <= fin;
            if (cnt_clear) data_q <= wr_data;
            if (state_q == ST_RD_TRUE && ack_ok) true_q <= slot_rbit;
            if (state_q == ST_RD_COMP && ack_ok) wbit_q <= br_wr;
            if (fin) begin
                result  <= acc_d;
                no_resp <= nores_d;
            end
        end
    end
endmodule

// File: rtl/osa_search_chk.sv
module osa_search_chk
    import osa_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic slot_req,
    input logic slot_ack,
    input logic slot_bit,
    input logic done
);
    logic [4:0] ack_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ack_cnt <= '0;
        else if (done) ack_cnt <= '0;
        else if (slot_req && slot_ack) ack_cnt <= ack_cnt + 1'b1;
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !slot_req);                                              // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R7
    AST_SLOT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ack_cnt == 5'(SEARCH_SLOTS) || ack_cnt == 5'(BYTE_BITS))); // R2
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack) |=> (slot_req && $stable(slot_bit)));     // R10
endmodule

bind osa_search_accel osa_search_chk u_chk (.*);

// File: tb/tb_osa_search_accel.sv
module tb_osa_search_accel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       search_en = 1'b0;
    logic       start = 1'b0;
    logic [7:0] wr_data = '0;
    logic       slot_ack = 1'b0;
    logic       slot_rbit = 1'b0;
    logic       slot_req, slot_bit, done, no_resp;
    logic [7:0] result;

    osa_search_accel dut (
        .clk(clk), .rst_n(rst_n), .search_en(search_en), .start(start),
        .wr_data(wr_data), .slot_req(slot_req), .slot_bit(slot_bit),
        .slot_ack(slot_ack), .slot_rbit(slot_rbit), .done(done),
        .result(result), .no_resp(no_resp)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural model state
    int    q_exp[$];
    int    q_rd[$];
    string q_tag[$];
    bit    m_busy = 0, m_done = 0, m_nores = 0, p_nores = 0;
    logic [7:0] m_res = '0, p_res = '0;
    int    lat = 1, waitc = 0, left = 0;
    bit    req_start = 0, req_mode = 0, armed = 0;
    logic [7:0] req_data = '0;
    string op_tag = "R1";

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(negedge clk) begin
        bit nb, nd;
        if (rst_n) begin
            cyc++;
            if (cyc > 50000) begin
                chk(1'b0, "R10", "watchdog", cyc, 0);
                finish_run();
            end
            chk(slot_req === m_busy, "R10", "slot_req", int'(slot_req), int'(m_busy));
            chk(done === m_done, "R7", "done", int'(done), int'(m_done));
            chk(result === m_res, op_tag, "result", int'(result), int'(m_res));
            chk(no_resp === m_nores, "R5", "no_resp", int'(no_resp), int'(m_nores));
            nb = m_busy;
            nd = 1'b0;
            slot_ack  = 1'b0;
            slot_rbit = 1'b0;
            if (m_busy && slot_req && q_exp.size() > 0) begin
                waitc++;
                if (waitc >= lat) begin
                    waitc     = 0;
                    slot_ack  = 1'b1;
                    slot_rbit = q_rd.pop_front() != 0;
                    chk(slot_bit === (q_exp[0] != 0), q_tag[0], "slot_bit",
                        int'(slot_bit), q_exp[0]);
                    void'(q_exp.pop_front());
                    void'(q_tag.pop_front());
                    left--;
                    if (left == 0) begin
                        nb = 1'b0;
                        nd = 1'b1;
                    end
                end
            end
            start = 1'b0;
            if (req_start) begin
                req_start = 1'b0;
                start     = 1'b1;
                search_en = req_mode;
                wr_data   = req_data;
                if (!m_busy && armed) begin
                    armed = 1'b0;
                    nb    = 1'b1;
                    waitc = 0;
                    left  = q_exp.size();
                end
            end
            m_busy = nb;
            m_done = nd;
            if (nd) begin
                m_res   = p_res;
                m_nores = p_nores;
            end
        end
    end

    // extra: 1 = poke a start mid-operation, 2 = flip search_en mid-operation
    task automatic run_op(bit mode, logic [7:0] data, logic [7:0] rd, int l,
                          string tag, int extra);
        logic [7:0] res = '0;
        bit nr = 0;
        if (mode) begin
            for (int i = 0; i < 4; i++) begin
                bit t = rd[2*i];
                bit c = rd[2*i+1];
                bit w, dsc;
                dsc = 0;
                if (t && c) begin
                    w = 1; nr = 1;
                end else if (!t && !c) begin
                    w = data[i]; dsc = 1;
                end else begin
                    w = t;
                end
                res[i]   = dsc;
                res[4+i] = w;
                q_exp.push_back(1); q_tag.push_back("R2"); q_rd.push_back(int'(t));
                q_exp.push_back(1); q_tag.push_back("R2"); q_rd.push_back(int'(c));
                q_exp.push_back(int'(w)); q_tag.push_back(tag); q_rd.push_back(0);
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                q_exp.push_back(int'(data[i]));
                q_tag.push_back("R8");
                q_rd.push_back(int'(rd[i]));
                res[i] = rd[i];
            end
        end
        @(posedge clk); #2;
        p_res = res; p_nores = nr; lat = l; op_tag = tag;
        armed = 1; req_mode = mode; req_data = data; req_start = 1;
        while (!m_busy) @(posedge clk);
        if (extra == 1) begin
            repeat (3) @(posedge clk); #2;
            req_mode = mode; req_data = ~data; req_start = 1;   // R9 ignored start
        end else if (extra == 2) begin
            repeat (4) @(posedge clk); #2;
            search_en = ~mode;                                 // R8 mode flip
        end
        while (m_busy) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        @(posedge clk); #5;
        chk(slot_req === 1'b0 && done === 1'b0 && result === 8'h00 && no_resp === 1'b0,
            "R1", "reset outputs", int'({slot_req, done, no_resp}), 0);
        run_op(0, 8'hA5, 8'h3C, 2, "R8", 0);
        run_op(1, 8'h00, 8'b01_10_10_01, 1, "R4", 0);
        run_op(1, 8'h0A, 8'h00, 3, "R3", 0);
        run_op(1, 8'h00, 8'hFF, 1, "R5", 0);
        run_op(1, 8'h01, 8'b00_11_01_00, 2, "R6", 0);
        run_op(1, 8'h05, 8'h12, 1, "R9", 1);
        run_op(0, 8'h5A, 8'hC3, 1, "R8", 2);
        run_op(1, 8'h0F, 8'h00, 1, "R3", 0);
        run_op(1, 8'h06, 8'b10_00_11_00, 3, "R6", 0);
        finish_run();
    end
endmodule